// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block sits on the device side of a byte-wide register window. A host moves a command through it and takes a response back. The host first claims the ready state by writing the status byte. It then writes the command one byte at a time into a shared data port and polls a status byte and a 16-bit burst count to pace those writes. The engine reads the command's own length from a big-endian size field at bytes 2 to 5 of the header. It lowers its expect flag once that many bytes have arrived.

When the host triggers execution, the stored command is streamed out to an executor over a valid/ready channel. The executor returns the response over a second valid/ready channel into the same buffer. The host then drains the response through the data port. It can rewind and re-read the response, or abort at any point by writing the ready bit again.

Back-pressure rules: on the command channel, once `cmd_valid` is high, the engine holds `cmd_data` and `cmd_last` stable until `cmd_ready` is seen. The only exception is an abort. On the response channel, `rsp_ready` rises only after the whole command has been handed over. The engine never stalls the response once `rsp_ready` is up.

Top module: `cmd_fifo_stat_eng`

## Requirements
- R1: The status byte at offset 0x18 reads bit 7 = 1 (valid), bit 6 = 1 in the ready state, bit 4 = 1 while unread response bytes remain, and bit 3 = 1 while command bytes are still expected. Bits 5, 2, 1 and 0 read 0. In the idle state the byte therefore reads 0x80, and in the ready state 0xC0.
- R2: A write to offset 0x18 with bit 6 set moves the engine from any state to the ready state. It also clears all buffer pointers, so the burst count again reads the full capacity.
- R3: A byte written to the data port (offset 0x24) in the ready state or while expecting is stored, and it moves a ready engine into reception. The command length is bytes 2..5 in big-endian order, raised to at least 6 and capped at the capacity (default 1280). Expect drops to 0 once that many bytes are held.
- R4: A byte written to the data port after the command is complete is dropped. It is neither stored nor forwarded.
- R5: A write to 0x18 with bit 5 set starts execution only in reception with expect = 0. In every other case it is ignored.
- R6: In execution the stored command is sent on `cmd_data` in write order. `cmd_last` is set on the final byte. Under back-pressure the data is held stable.
- R7: After the last command byte, `rsp_ready` rises and response bytes are stored from index 0. The byte carrying `rsp_last` moves the engine to completion. Bytes beyond capacity are accepted and dropped.
- R8: The burst count is at offset 0x19 (low byte) and 0x1A (high byte). In the ready state, or in reception while expecting, it reads capacity minus bytes written. In completion it reads the number of response bytes still unread. In all other cases it reads 0.
- R9: In completion, a data-port read returns the next response byte and advances. Data-available clears after the last byte. A data-port read with nothing available returns 0xFF and does not advance.
- R10: A write to 0x18 with bit 1 set in completion rewinds the read position to the first response byte.
- R11: A read of any other offset returns 0xFF. While `owned` is low, every read returns 0xFF and every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owned | input | 1 | Host currently holds this port |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 12 | Register byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| cmd_valid | output | 1 | Command byte valid to executor |
| cmd_ready | input | 1 | Executor accepts command byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final command byte |
| rsp_valid | input | 1 | Response byte valid from executor |
| rsp_ready | output | 1 | Engine accepts response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |

## Verification
The bench sends a byte past the end of a command. A design that stored it would forward an eleventh byte to the executor and show a nonzero burst count. It writes go while bytes are still expected; a design that honoured it would leave reception early, and the status byte would lose its expect bit. It declares a size of 2 in the header, which the length clamp must raise to 6; a design without the clamp would drop expect after 2 bytes or hang waiting. Finally, it overfills the response past capacity and uses rewind followed by abort; a wrong pointer update shows up as a wrong byte, a wrong burst count, or an executor that deadlocks.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_RECEPTION,
    ST_EXECUTION,
    ST_COMPLETION
  } cfe_state_e;

  localparam int OFS_STATUS   = 'h018;
  localparam int OFS_BURST_LO = 'h019;
  localparam int OFS_BURST_HI = 'h01A;
  localparam int OFS_FIFO     = 'h024;

  localparam int BIT_VALID  = 7;
  localparam int BIT_READY  = 6;
  localparam int BIT_GO     = 5;
  localparam int BIT_AVAIL  = 4;
  localparam int BIT_EXPECT = 3;
  localparam int BIT_RETRY  = 1;

  localparam int HDR_BYTES = 6;
endpackage

// File: rtl/cfe_buffer.sv
module cfe_buffer #(
  parameter int DEPTH = 1280,
  parameter int MAW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic [MAW-1:0] raddr_a,
  output logic [7:0]     rdata_a,
  input  logic [MAW-1:0] raddr_b,
  output logic [7:0]     rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cfe_len_track.sv
module cfe_len_track
  import cfe_pkg::*;
#(
  parameter int DEPTH = 1280,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             byte_we,
  input  logic [PTR_W-1:0] byte_idx,
  input  logic [7:0]       byte_val,
  input  logic [PTR_W-1:0] count,
  output logic [PTR_W-1:0] target,
  output logic             done
);
  logic [31:0] size_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      size_q <= '0;
    end else if (byte_we) begin
      if (byte_idx == PTR_W'(2)) size_q[31:24] <= byte_val;
      if (byte_idx == PTR_W'(3)) size_q[23:16] <= byte_val;
      if (byte_idx == PTR_W'(4)) size_q[15:8]  <= byte_val;
      if (byte_idx == PTR_W'(5)) size_q[7:0]   <= byte_val;
    end
  end

  always_comb begin
    if (size_q < 32'(HDR_BYTES))   target = PTR_W'(HDR_BYTES);
    else if (size_q > 32'(DEPTH))  target = PTR_W'(DEPTH);
    else                           target = size_q[PTR_W-1:0];
  end

  assign done = (count >= target);

  p_target_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (target >= PTR_W'(HDR_BYTES)) && (target <= PTR_W'(DEPTH)));
endmodule

// File: rtl/cfe_rd_mux.sv
module cfe_rd_mux
  import cfe_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          owned,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    status_byte,
  input  logic [15:0]   burst,
  input  logic [7:0]    fifo_byte,
  input  logic          fifo_avail,
  output logic [7:0]    rdata
);
  always_comb begin
    rdata = 8'hFF;
    if (owned) begin
      if (addr == AW'(OFS_STATUS))        rdata = status_byte;
      else if (addr == AW'(OFS_BURST_LO)) rdata = burst[7:0];
      else if (addr == AW'(OFS_BURST_HI)) rdata = burst[15:8];
      else if (addr == AW'(OFS_FIFO))     rdata = fifo_avail ? fifo_byte : 8'hFF;
    end
  end
endmodule

// File: rtl/cmd_fifo_stat_eng.sv
module cmd_fifo_stat_eng
  import cfe_pkg::*;
#(
  parameter int DEPTH = 1280,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          owned,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          host_rvalid,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [7:0]    cmd_data,
  output logic          cmd_last,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_last
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int MAW   = $clog2(DEPTH);

  cfe_state_e       state;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, rsp_len, out_ptr;
  logic             cmd_sent;

  // host decode
  logic sts_wr, ready_cmd, go_cmd, retry_cmd, fifo_wr, fifo_rd;
  assign sts_wr    = host_wr && owned && (host_addr == AW'(OFS_STATUS));
  assign ready_cmd = sts_wr && host_wdata[BIT_READY];
  assign go_cmd    = sts_wr && host_wdata[BIT_GO];
  assign retry_cmd = sts_wr && host_wdata[BIT_RETRY];
  assign fifo_wr   = host_wr && owned && (host_addr == AW'(OFS_FIFO));
  assign fifo_rd   = host_rd && owned && (host_addr == AW'(OFS_FIFO));

  // command length tracking
  logic [PTR_W-1:0] target;
  logic             len_done;
  logic             rx_accept;

  cfe_len_track #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ready_cmd),
    .byte_we  (rx_accept),
    .byte_idx (wr_ptr),
    .byte_val (host_wdata),
    .count    (wr_ptr),
    .target   (target),
    .done     (len_done)
  );

  logic expect_w, data_avail, fifo_pop, cmd_fire, rsp_fire, rsp_store;
  assign expect_w   = (state == ST_RECEPTION) && !len_done;
  assign rx_accept  = fifo_wr && !ready_cmd &&
                      ((state == ST_READY) || expect_w) && (wr_ptr < PTR_W'(DEPTH));
  assign data_avail = (state == ST_COMPLETION) && (rd_ptr < rsp_len);
  assign fifo_pop   = fifo_rd && data_avail;

  assign cmd_valid  = (state == ST_EXECUTION) && !cmd_sent;
  assign cmd_last   = (out_ptr == target - PTR_W'(1));
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign rsp_ready  = (state == ST_EXECUTION) && cmd_sent;
  assign rsp_fire   = rsp_valid && rsp_ready;
  assign rsp_store  = rsp_fire && (rsp_len < PTR_W'(DEPTH));

  // shared buffer
  logic           buf_we;
  logic [MAW-1:0] buf_waddr;
  logic [7:0]     buf_wdata, fifo_byte;

  always_comb begin
    buf_we    = rx_accept || rsp_store;
    buf_waddr = rx_accept ? wr_ptr[MAW-1:0] : rsp_len[MAW-1:0];
    buf_wdata = rx_accept ? host_wdata : rsp_data;
  end

  cfe_buffer #(.DEPTH(DEPTH), .MAW(MAW)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (out_ptr[MAW-1:0]),
    .rdata_a (cmd_data),
    .raddr_b (rd_ptr[MAW-1:0]),
    .rdata_b (fifo_byte)
  );

  // status and burst count
  logic [7:0]  status_byte;
  logic [15:0] burst;

  always_comb begin
    status_byte             = '0;
    status_byte[BIT_VALID]  = 1'b1;
    status_byte[BIT_READY]  = (state == ST_READY);
    status_byte[BIT_AVAIL]  = data_avail;
    status_byte[BIT_EXPECT] = expect_w;
  end

  always_comb begin
    if ((state == ST_READY) || expect_w) burst = 16'(PTR_W'(DEPTH) - wr_ptr);
    else if (state == ST_COMPLETION)     burst = 16'(rsp_len - rd_ptr);
    else                                 burst = '0;
  end

  logic [7:0] rd_mux;
  cfe_rd_mux #(.AW(AW)) u_mux (
    .owned       (owned),
    .addr        (host_addr),
    .status_byte (status_byte),
    .burst       (burst),
    .fifo_byte   (fifo_byte),
    .fifo_avail  (data_avail),
    .rdata       (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  // transaction state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      rsp_len  <= '0;
      out_ptr  <= '0;
      cmd_sent <= 1'b0;
    end else if (ready_cmd) begin
      state    <= ST_READY;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      rsp_len  <= '0;
      out_ptr  <= '0;
      cmd_sent <= 1'b0;
    end else begin
      case (state)
        ST_READY: begin
          if (rx_accept) begin
            state  <= ST_RECEPTION;
            wr_ptr <= wr_ptr + PTR_W'(1);
          end
        end
        ST_RECEPTION: begin
          if (rx_accept)             wr_ptr <= wr_ptr + PTR_W'(1);
          else if (go_cmd && len_done) state <= ST_EXECUTION;
        end
        ST_EXECUTION: begin
          if (cmd_fire) begin
            out_ptr <= out_ptr + PTR_W'(1);
            if (cmd_last) cmd_sent <= 1'b1;
          end
          if (rsp_fire) begin
            if (rsp_store) rsp_len <= rsp_len + PTR_W'(1);
            if (rsp_last)  state   <= ST_COMPLETION;
          end
        end
        ST_COMPLETION: begin
          if (retry_cmd)     rd_ptr <= '0;
          else if (fifo_pop) rd_ptr <= rd_ptr + PTR_W'(1);
        end
        default: ;
      endcase
    end
  end

  // properties guarding the state machine
  p_ready_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_cmd |=> (state == ST_READY) && (wr_ptr == '0) && (rd_ptr == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PTR_W'(DEPTH));

  p_drop_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RECEPTION) && len_done && fifo_wr && !ready_cmd) |=> $stable(wr_ptr));

  p_go_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expect_w && go_cmd && !ready_cmd) |=> (state == ST_RECEPTION));

  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !ready_cmd) |=>
      (cmd_valid && $stable(cmd_data) && $stable(cmd_last)));

  p_rsp_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !cmd_valid);

  p_rd_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= rsp_len);
endmodule

// File: tb/cmd_fifo_stat_eng_tb_top.sv
`timescale 1ns/1ps
module cmd_fifo_stat_eng_tb_top;
  localparam int DEPTH = 1280;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        owned = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        cmd_valid, cmd_last, rsp_ready;
  logic        cmd_ready = 1'b1;
  logic [7:0]  cmd_data;
  logic        rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [7:0]  rsp_data = '0;

  always #2 clk = ~clk;

  cmd_fifo_stat_eng #(.DEPTH(DEPTH), .AW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .owned(owned),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard: driver pushes expected read bytes, monitor compares
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always @(negedge clk) begin
    if (host_rvalid) begin
      if (exp_q.size() == 0) chk("scoreboard-underflow", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, host_rdata, e);
      end
    end
  end

  task automatic hwrite(int a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 12'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(int a, logic [7:0] e, string req);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(req);
    host_rd = 1'b1; host_addr = 12'(a);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // executor model
  logic [7:0] got_cmd[$];
  int         got_last = 0;
  bit         bp_en = 0;

  always @(posedge clk) begin
    if (cmd_valid && cmd_ready) begin
      got_cmd.push_back(cmd_data);
      if (cmd_last) got_last++;
    end
  end

  always @(negedge clk) cmd_ready <= bp_en ? ~cmd_ready : 1'b1;

  task automatic send_rsp(logic [7:0] b, bit last);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = b; rsp_last = last;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic wait_last(int n);
    while (got_last < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [7:0] cmd_a [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A,
                            8'h11, 8'h22, 8'h33, 8'h44};
  logic [7:0] rsp_a [8]  = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h08,
                            8'h5A, 8'hC3};
  logic [7:0] cmd_b [6]  = '{8'h80, 8'h02, 8'h00, 8'h00, 8'h00, 8'h02};

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R11: not owned
    hread('h018, 8'hFF, "R11 unowned read");
    hwrite('h018, 8'h40);
    owned = 1'b1;
    hread('h018, 8'h80, "R11 unowned write ignored / R1 idle");
    hread('h019, 8'h00, "R8 idle burst");

    // R2: enter ready
    hwrite('h018, 8'h40);
    hread('h018, 8'hC0, "R2 ready status / R1");
    hread('h019, 8'h00, "R8 burst low ready");
    hread('h01A, 8'h05, "R8 burst high ready");

    // R3 reception
    for (int i = 0; i < 5; i++) hwrite('h024, cmd_a[i]);
    hread('h018, 8'h88, "R3 expecting");
    hread('h019, 8'hFB, "R8 burst low rx");
    hread('h01A, 8'h04, "R8 burst high rx");
    hwrite('h018, 8'h20);
    hread('h018, 8'h88, "R5 go ignored while expecting");
    for (int i = 5; i < 10; i++) hwrite('h024, cmd_a[i]);
    hread('h018, 8'h80, "R3 expect dropped");
    hwrite('h024, 8'hEE);
    hread('h019, 8'h00, "R4 burst zero after complete");

    // R6 execute with back-pressure
    bp_en = 1;
    hwrite('h018, 8'h20);
    wait_last(1);
    bp_en = 0;
    chk("R4 command byte count", got_cmd.size(), 10);
    for (int i = 0; i < 10 && i < got_cmd.size(); i++)
      chk("R6 command byte order", got_cmd[i], cmd_a[i]);
    hread('h018, 8'h80, "R1 executing status");

    // R7 response
    for (int i = 0; i < 8; i++) send_rsp(rsp_a[i], i == 7);
    hread('h018, 8'h90, "R7 completion / R1 data avail");
    hread('h019, 8'h08, "R8 burst unread");
    for (int i = 0; i < 8; i++) hread('h024, rsp_a[i], "R9 response byte");
    hread('h018, 8'h80, "R9 data avail cleared");
    hread('h024, 8'hFF, "R9 empty read");
    hread('h019, 8'h00, "R9 empty read no advance");

    // R10 retry
    hwrite('h018, 8'h02);
    hread('h019, 8'h08, "R10 rewind burst");
    for (int i = 0; i < 3; i++) hread('h024, rsp_a[i], "R10 reread byte");
    hread('h019, 8'h05, "R10 burst after reread");

    // R2 abort from completion
    hwrite('h018, 8'h40);
    hread('h018, 8'hC0, "R2 abort to ready");

    // R3 clamp of a short declared size, R11 unmapped
    for (int i = 0; i < 5; i++) hwrite('h024, cmd_b[i]);
    hread('h018, 8'h88, "R3 short size still expecting");
    hwrite('h024, cmd_b[5]);
    hread('h018, 8'h80, "R3 short size completes at 6");
    hread('h01B, 8'hFF, "R11 unmapped 0x1B");
    hread('h000, 8'hFF, "R11 unmapped 0x00");

    // R7 overfill past capacity
    got_cmd.delete();
    hwrite('h018, 8'h20);
    wait_last(2);
    chk("R6 short command byte count", got_cmd.size(), 6);
    for (int i = 0; i < DEPTH + 5; i++) send_rsp(8'(i), i == DEPTH + 4);
    hread('h019, 8'h00, "R7 capped burst low");
    hread('h01A, 8'h05, "R7 capped burst high");
    hread('h024, 8'h00, "R7 first stored byte");
    hread('h024, 8'h01, "R7 second stored byte");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule